// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

A register-mapped serial unit that exchanges bytes over a three-wire synchronous link: one serial data input, one serial data output and one serial clock. There is no select line. An 8-bit shift register sends its most significant bit first and takes each received bit in at its least significant end. After sixteen serial clock edges (eight bit periods), the byte that was loaded has gone out and the partner's byte sits in the register. A 4-bit edge counter advances on every serial clock edge. When it wraps, it sets a sticky completion flag that software polls to detect the end of a byte.

In master mode there is no baud generator. Software makes every clock edge by writing a toggle strobe to the control register, and each such write inverts the serial clock output. In slave mode the serial clock comes from outside. It passes through a two-flop synchroniser, and its edges are detected in the system clock domain. A control bit chooses the sampling edge, which gives the two common clock-phase variants with an idle-low clock: sample on rising edges or sample on falling edges. A small write/read port reaches the data, control and status registers. Software can also preset the edge count through the status register.

Top module: `tws_top`

## Requirements
- R1: After reset the data, control and status registers read 0x00, and both sdo_o and sck_out_o are 0.
- R2: Register map: address 0 is data, 1 is control, 2 is status, and 3 reads 0x00. A data write loads all 8 bits in parallel. A read returns the current contents one clock after the address is presented and changes neither the counter nor the flag.
- R3: Control bit 0 selects master mode (1) and bit 1 is the edge select. Bit 2 is a write-only toggle strobe that reads as 0. In master mode each write with bit 2 set inverts sck_out_o, and the resulting edge shifts and counts one clock after the write is accepted. In slave mode the strobe has no effect.
- R4: Data moves MSB first. sdo_o presents bit 7 of the register, and on each sampling edge sdi_i enters at bit 0. After 16 clock edges the register holds the 8 received bits, and the 8 loaded bits have appeared on sdo_o in order from bit 7 to bit 0.
- R5: With edge select 0, data is sampled on rising serial clock edges and sdo_o changes on falling edges. With edge select 1, sampling is on falling edges and sdo_o changes on rising edges.
- R6: The 4-bit counter (status bits 3:0) advances on both serial clock edges. An edge taken at count 15 wraps the count to 0 and sets the flag in status bit 7. The flag stays set until software writes a 1 to bit 7; writing 0 there leaves it as it is.
- R7: A status write loads bits 3:0 into the counter, so a transfer can start from a preset count.
- R8: In slave mode, sck_in_i passes through a two-flop synchroniser. Each level held for at least four system clocks yields exactly one edge. In master mode sck_in_i is ignored.
- R9: When a register write and a serial edge fall in the same cycle, the written data value and the written count win over the shift and the increment. A wrap sets the flag even if a clear is written in that cycle.
- R10: sdo_o changes only on a change edge or on a data write, which places bit 7 of the written byte on it at once. It holds steady through the sampling half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sck_in_i | input | 1 | External serial clock (slave mode) |
| sck_out_o | output | 1 | Generated serial clock (master mode) |

## Verification
A software register write can land in the same system clock cycle as a serial clock edge. In master mode this happens when a second write is issued right after a toggle write, because the toggle's edge acts one clock later. The bench uses this to collide a status write that clears the flag and loads a new count with the edge that wraps the counter from 15. The flag must stay set and the written count must stick. It also collides a data write with a sampling edge, where the written byte must be read back unshifted and its top bit must appear on sdo_o.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } tws_addr_e;

  localparam int unsigned CTL_MASTER = 0;
  localparam int unsigned CTL_ESEL   = 1;
  localparam int unsigned CTL_TGL    = 2;
endpackage

// File: rtl/tws_sck_front.sv
module tws_sck_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic tgl,
  input  logic sck_ext,
  output logic sck_o,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sck_q;
  logic prev_q;
  logic src;

  assign src   = master ? sck_q : sync_q[SYNC_STAGES-1];
  assign rise  = src & ~prev_q;
  assign fall  = ~src & prev_q;
  assign sck_o = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      sck_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sck_ext};
      prev_q <= src;
      if (master && tgl) sck_q <= ~sck_q;
    end
  end

  // R3: a master toggle inverts the clock output
  a_r3_toggle_inverts: assert property (@(posedge clk) disable iff (rst)
    (master && tgl) |=> (sck_o != $past(sck_o)));
  // R3: no toggle, no change of the generated clock
  a_r3_no_toggle_hold: assert property (@(posedge clk) disable iff (rst)
    !(master && tgl) |=> $stable(sck_o));
endmodule

// File: rtl/tws_shift_core.sv
module tws_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample,
  input  logic              change,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo
);
  logic [DATA_W-1:0] sr_q;
  logic              do_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      do_q <= 1'b0;
    end else if (load) begin
      sr_q <= load_data;
      do_q <= load_data[DATA_W-1];
    end else begin
      if (sample) sr_q <= {sr_q[DATA_W-2:0], sdi};
      if (change) do_q <= sr_q[DATA_W-1];
    end
  end

  assign shreg = sr_q;
  assign sdo   = do_q;

  // R10: output latch holds outside change edges and loads
  a_r10_sdo_steady: assert property (@(posedge clk) disable iff (rst)
    (!change && !load) |=> $stable(sdo));
  // R9: a load beats a coincident shift
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (shreg == $past(load_data)));
endmodule

// File: rtl/tws_edge_counter.sv
module tws_edge_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_any,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = edge_any && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr)        cnt_q <= cnt_wdata;
      else if (edge_any) cnt_q <= cnt_q + 1'b1;
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  // R6: edge at the top count raises the flag
  a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (edge_any && cnt == CNT_MAX) |=> flag);
  // R6: flag is sticky without a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  // R2: with no edge and no write the count holds
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!edge_any && !cnt_wr) |=> $stable(cnt));
endmodule

// File: rtl/tws_top.sv
module tws_top
  import tws_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              sck_in_i,
  output logic              sck_out_o
);
  localparam int unsigned CNT_W = $clog2(2 * DATA_W);

  logic              master_q;
  logic              esel_q;
  logic              wr_data, wr_ctrl, wr_stat;
  logic              tgl;
  logic              rise, fall, sample, change, edge_any;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              flag;
  logic [DATA_W-1:0] stat_w, ctrl_w, rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign wr_data = reg_wr && (tws_addr_e'(reg_addr) == A_DATA);
  assign wr_ctrl = reg_wr && (tws_addr_e'(reg_addr) == A_CTRL);
  assign wr_stat = reg_wr && (tws_addr_e'(reg_addr) == A_STAT);
  assign tgl     = wr_ctrl && reg_wdata[CTL_TGL];

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      esel_q   <= 1'b0;
    end else if (wr_ctrl) begin
      master_q <= reg_wdata[CTL_MASTER];
      esel_q   <= reg_wdata[CTL_ESEL];
    end
  end

  tws_sck_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk     (clk),
    .rst     (rst),
    .master  (master_q),
    .tgl     (tgl),
    .sck_ext (sck_in_i),
    .sck_o   (sck_out_o),
    .rise    (rise),
    .fall    (fall)
  );

  assign sample   = esel_q ? fall : rise;
  assign change   = esel_q ? rise : fall;
  assign edge_any = rise | fall;

  tws_shift_core #(.DATA_W(DATA_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_data),
    .load_data (reg_wdata),
    .sample    (sample),
    .change    (change),
    .sdi       (sdi_i),
    .shreg     (shreg),
    .sdo       (sdo_o)
  );

  tws_edge_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .edge_any  (edge_any),
    .cnt_wr    (wr_stat),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .flag_clr  (wr_stat && reg_wdata[DATA_W-1]),
    .cnt       (cnt),
    .flag      (flag)
  );

  always_comb begin
    stat_w              = '0;
    stat_w[CNT_W-1:0]   = cnt;
    stat_w[DATA_W-1]    = flag;
    ctrl_w              = '0;
    ctrl_w[CTL_MASTER]  = master_q;
    ctrl_w[CTL_ESEL]    = esel_q;
    case (tws_addr_e'(reg_addr))
      A_DATA:  rd_mux = shreg;
      A_CTRL:  rd_mux = ctrl_w;
      A_STAT:  rd_mux = stat_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R5: a sampling edge and a change edge never coincide
  a_r5_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sample && change));
  // R3: the strobe bit never reads back
  a_r3_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(tws_addr_e'(reg_addr)) == A_CTRL) |-> !reg_rdata[CTL_TGL]);
endmodule

// File: tb/tws_top_tb_top.sv
module tws_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sdi_i = 1'b0;
  logic       sdo_o;
  logic       sck_in_i = 1'b0;
  logic       sck_out_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_top dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sck_in_i(sck_in_i), .sck_out_o(sck_out_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_wr = 1'b0;
    tick();
    d = reg_rdata;
  endtask

  function automatic logic [7:0] ctl_val(input bit m, input bit sel, input bit t);
    return {5'b0, t, sel, m};
  endfunction

  // one byte exchange; returns bits seen on sdo_o
  task automatic xfer(input bit m, input bit sel, input logic [7:0] d,
                      input logic [7:0] s, output logic [7:0] seen);
    logic lvl;
    seen = 8'h00;
    lvl  = 1'b0;
    reg_write(2'd1, ctl_val(m, sel, 1'b0));
    reg_write(2'd0, d);
    for (int k = 0; k < 16; k++) begin
      bit is_sample;
      lvl = ~lvl;
      is_sample = (lvl == ~sel);
      if (is_sample) sdi_i = s[7 - k/2];
      if (m) begin
        reg_write(2'd1, ctl_val(m, sel, 1'b1));
        tick();
      end else begin
        sck_in_i = lvl;
        repeat (4) tick();
      end
      if (is_sample) seen = {seen[6:0], sdo_o};
    end
  endtask

  logic [7:0] rd, seen, d, s;

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    reg_read(2'd0, rd); chk("R1 data", rd, 8'h00);
    reg_read(2'd1, rd); chk("R1 ctrl", rd, 8'h00);
    reg_read(2'd2, rd); chk("R1 stat", rd, 8'h00);
    chk("R1 sdo", sdo_o, 0);
    chk("R1 sck", sck_out_o, 0);

    // R2 map and parallel load
    reg_write(2'd0, 8'hA5);
    reg_read(2'd0, rd); chk("R2 data load", rd, 8'hA5);
    chk("R10 sdo after load", sdo_o, 1);
    reg_read(2'd3, rd); chk("R2 addr3", rd, 8'h00);
    reg_read(2'd2, rd); chk("R2 read keeps count", rd, 8'h00);

    // R3 strobe in slave mode has no effect
    reg_write(2'd1, ctl_val(1'b0, 1'b0, 1'b1));
    tick(); tick();
    chk("R3 slave strobe sck", sck_out_o, 0);
    reg_read(2'd2, rd); chk("R3 slave strobe count", rd, 8'h00);
    reg_read(2'd1, rd); chk("R3 strobe reads 0", rd, 8'h00);

    // R8 master ignores sck_in_i
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b0));
    for (int i = 0; i < 4; i++) begin sck_in_i = ~sck_in_i; repeat (4) tick(); end
    reg_read(2'd2, rd); chk("R8 master ignores ext clock", rd, 8'h00);

    // R4 R5 R6 directed: each mode, master and slave
    for (int v = 0; v < 4; v++) begin
      d = 8'hC3 ^ 8'(v * 8'h11); s = 8'h5A ^ 8'(v * 8'h27);
      xfer(v[0], v[1], d, s, seen);
      reg_read(2'd0, rd); chk("R4 received byte", rd, s);
      chk("R4 R5 sent bits", seen, d);
      reg_read(2'd2, rd); chk("R6 flag after 16 edges", rd, 8'h80);
      reg_write(2'd2, 8'h00);
      reg_read(2'd2, rd); chk("R6 write 0 keeps flag", rd, 8'h80);
      reg_write(2'd2, 8'h80);
      reg_read(2'd2, rd); chk("R6 clear flag", rd, 8'h00);
    end

    // R7 preset count: 8 edges from 8 reach wrap
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b0));
    reg_write(2'd2, 8'h08);
    for (int k = 0; k < 8; k++) begin
      reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b1)); tick();
    end
    reg_read(2'd2, rd); chk("R7 preset count wrap", rd, 8'h80);
    reg_write(2'd2, 8'h80);

    // R9 collision: wrap edge with clear + count write
    reg_write(2'd2, 8'h0F);
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b1));
    reg_write(2'd2, 8'h85);
    reg_read(2'd2, rd); chk("R9 set beats clear, count wins", rd, 8'h85);
    reg_write(2'd2, 8'h85);
    reg_read(2'd2, rd); chk("R9 later clear", rd, 8'h05);

    // R9 collision: data write with sampling edge (sck now 1)
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b1)); tick();
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b1));
    reg_write(2'd0, 8'h3C);
    tick();
    reg_read(2'd0, rd); chk("R9 data write beats shift", rd, 8'h3C);
    chk("R10 sdo from written byte", sdo_o, 0);
    reg_write(2'd1, ctl_val(1'b1, 1'b0, 1'b1)); tick();
    chk("R3 clock back low", sck_out_o, 0);
    reg_write(2'd2, 8'h80);

    // random exchanges
    for (int n = 0; n < 16; n++) begin
      bit m, sel;
      m = 1'($urandom); sel = 1'($urandom);
      d = 8'($urandom); s = 8'($urandom);
      xfer(m, sel, d, s, seen);
      reg_read(2'd0, rd); chk("R4 random received", rd, s);
      chk("R5 random sent", seen, d);
      reg_read(2'd2, rd); chk("R6 random flag", rd, 8'h80);
      reg_write(2'd2, 8'h80);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule